// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block places a single-way cache in front of a line-granular memory port. A requester issues 32-bit reads and byte-masked 32-bit writes through a valid/ready request channel. Each access that hits returns a response on the following cycle with no downstream traffic. A miss stalls the request channel while a controller replaces the addressed line. If the old line holds modified data, the controller first writes the whole line back. It then reads the new line and finally completes the pending access against it.

Writes follow a write-back, write-allocate policy. A write miss brings the line in before merging into it, and a modified line reaches memory only when another line displaces it. The same module serves instruction fetch when its read-only parameter is set. In that mode it never marks a line modified, never writes downstream and discards write data. Lines are 32 bytes long and the cache is meant for the 1 GiB region starting at 0x8000_0000. After reset the block walks its line table and invalidates every entry before it accepts any request.

Top module: `line_cache`

## Requirements
- R1: After reset, reqReady and rspValid stay low. reqReady rises after exactly NUM_LINES clock cycles of invalidation, and the first access to any line then misses and issues a downstream read.
- R2: A read that hits is accepted with reqReady high. rspValid is high for one cycle, on the cycle after acceptance, with the stored word, and no downstream request is issued.
- R3: A write that hits replaces byte b (bits 8b+7:8b) of the addressed word exactly where reqMask bit b is 1, keeps the other bytes, responds one cycle after acceptance and issues no downstream request.
- R4: A read miss issues a downstream read whose dnAddr is the request address with bits 4:0 cleared. After dnRspValid, the response carries word w = dnRdata[32w+31:32w], where w = reqAddr[4:2].
- R5: A write miss fetches the line first and then merges the masked bytes into it (write-allocate). The other words of that line keep their fetched values, and the line becomes modified.
- R6: A miss whose victim line is valid and modified first issues one downstream write of the whole 256-bit line to the victim's line address, and the read request follows directly. A clean victim produces no downstream write.
- R7: The line index is reqAddr[4+log2(NUM_LINES):5] and the tag is the bits above it. Two addresses with equal index and different tag displace each other, while addresses with different index coexist.
- R8: A downstream request keeps dnReqValid, dnReqWrite and dnAddr unchanged until dnReqReady is seen. Only one miss is in progress at a time, and reqReady stays low from a miss's acceptance until its response.
- R9: With READ_ONLY=1, a write request leaves the stored data unchanged, and dnReqWrite is never asserted with dnReqValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Upstream access request present |
| reqReady | output | 1 | Cache accepts a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the word |
| reqWdata | input | 32 | Write data |
| reqMask | input | 4 | Byte enables, bit b covers bits 8b+7:8b |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 32 | Read data returned with rspValid |
| dnReqValid | output | 1 | Downstream line request present |
| dnReqReady | input | 1 | Downstream accepts the request |
| dnReqWrite | output | 1 | 1 = line write-back, 0 = line read |
| dnAddr | output | ADDR_W | Line address, low 5 bits zero |
| dnWdata | output | 256 | Line written back |
| dnRspValid | input | 1 | Read line returned |
| dnRdata | input | 256 | Returned line |

## Verification
The bench builds one writable instance with NUM_LINES=8 and one read-only instance with NUM_LINES=4. Both sit over a 64-line memory model that stalls dnReqReady at random. With so few lines, random addresses over 64 lines hit the same index very often. Evictions of modified and clean victims, and write-allocate on a miss, therefore occur constantly rather than only in directed cases. The small table also makes the invalidation sweep after reset short enough to count cycle by cycle.

// File: rtl/line_cache_pkg.sv
package line_cache_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } ctlState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;    // invalidate entry at clrIdx
    logic capture;  // latch the incoming request
    logic useCap;   // look up with the latched request
    logic wbAddr;   // drive the victim line address downstream
    logic access;   // perform read/write and raise the response
    logic install;  // write the returned line into the table
  } cacheCtl_t;

endpackage

// File: rtl/line_cache_datapath.sv
module line_cache_datapath
  import line_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES = 64,
  parameter bit READ_ONLY = 1'b0,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int WORDS = LINE_BYTES / 4,
  localparam int WORD_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheCtl_t         ctl,
  input  logic [IDX_W-1:0]  clrIdx,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqMask,
  input  logic [LINE_W-1:0] dnRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [LINE_W-1:0] dnWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata
);

  logic [LINE_W-1:0] dataQ [NUM_LINES];
  logic [TAG_W-1:0]  tagQ  [NUM_LINES];
  logic [NUM_LINES-1:0] validQ;
  logic [NUM_LINES-1:0] dirtyQ;

  logic              capWrite;
  logic [ADDR_W-1:0] capAddr;
  logic [31:0]       capWdata;
  logic [3:0]        capMask;

  logic              selWrite;
  logic [ADDR_W-1:0] selAddr;
  logic [31:0]       selWdata;
  logic [3:0]        selMask;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WORD_W-1:0] wordSel;
  logic [LINE_W-1:0] lineRd;
  logic [31:0]       oldWord;
  logic [31:0]       newWord;
  logic              writeHit;
  logic              unusedLowBits;

  assign selWrite = ctl.useCap ? capWrite : reqWrite;
  assign selAddr  = ctl.useCap ? capAddr  : reqAddr;
  assign selWdata = ctl.useCap ? capWdata : reqWdata;
  assign selMask  = ctl.useCap ? capMask  : reqMask;

  assign idx     = selAddr[OFF_W +: IDX_W];
  assign tag     = selAddr[ADDR_W-1 -: TAG_W];
  assign wordSel = selAddr[2 +: WORD_W];
  assign unusedLowBits = ^selAddr[1:0];

  assign lineRd      = dataQ[idx];
  assign oldWord     = lineRd[{wordSel, 5'd0} +: 32];
  assign hit         = validQ[idx] && (tagQ[idx] == tag);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign writeHit    = ctl.access && selWrite && !READ_ONLY;

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      newWord[8*b +: 8] = selMask[b] ? selWdata[8*b +: 8] : oldWord[8*b +: 8];
    end
  end

  assign dnAddr  = ctl.wbAddr ? {tagQ[idx], idx, {OFF_W{1'b0}}}
                              : {selAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign dnWdata = lineRd;

  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      capWrite <= reqWrite;
      capAddr  <= reqAddr;
      capWdata <= reqWdata;
      capMask  <= reqMask;
    end
  end

  // line storage: no reset, the valid bits are swept by the controller
  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      validQ[clrIdx] <= 1'b0;
    end
    if (ctl.install) begin
      dataQ[idx]  <= dnRdata;
      tagQ[idx]   <= tag;
      validQ[idx] <= 1'b1;
    end else if (writeHit) begin
      dataQ[idx][{wordSel, 5'd0} +: 32] <= newWord;
    end
  end

  generate
    if (READ_ONLY) begin : g_roDirty
      assign dirtyQ = '0;
    end else begin : g_rwDirty
      always_ff @(posedge clk) begin
        if (ctl.clear) begin
          dirtyQ[clrIdx] <= 1'b0;
        end
        if (ctl.install) begin
          dirtyQ[idx] <= 1'b0;
        end else if (writeHit) begin
          dirtyQ[idx] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= ctl.access;
      if (ctl.access) begin
        rspRdata <= oldWord;
      end
    end
  end

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.install) |-> hit);

  // R2
  rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.access |=> rspValid);

endmodule

// File: rtl/line_cache_control.sv
module line_cache_control
  import line_cache_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter bit READ_ONLY = 1'b0,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             hit,
  input  logic             victimDirty,
  input  logic             dnReqReady,
  input  logic             dnRspValid,
  output logic             reqReady,
  output logic             dnReqValid,
  output logic             dnReqWrite,
  output cacheCtl_t        ctl,
  output logic [IDX_W-1:0] clrIdx
);

  ctlState_e stateQ, stateD;
  logic [IDX_W-1:0] clrQ, clrD;
  logic sentQ, sentD;

  assign clrIdx = clrQ;

  always_comb begin
    ctl        = '0;
    stateD     = stateQ;
    clrD       = clrQ;
    sentD      = sentQ;
    reqReady   = 1'b0;
    dnReqValid = 1'b0;
    dnReqWrite = 1'b0;
    case (stateQ)
      ST_INIT: begin
        ctl.clear = 1'b1;
        clrD = clrQ + IDX_W'(1);
        if (clrQ == IDX_W'(NUM_LINES - 1)) begin
          stateD = ST_IDLE;
        end
      end
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (hit) begin
            ctl.access = 1'b1;
          end else begin
            ctl.capture = 1'b1;
            stateD = victimDirty ? ST_WRITEBACK : ST_REFILL;
          end
        end
      end
      ST_WRITEBACK: begin
        ctl.useCap = 1'b1;
        ctl.wbAddr = 1'b1;
        dnReqValid = 1'b1;
        dnReqWrite = 1'b1;
        if (dnReqReady) begin
          stateD = ST_REFILL;
        end
      end
      ST_REFILL: begin
        ctl.useCap = 1'b1;
        if (!sentQ) begin
          dnReqValid = 1'b1;
          if (dnReqReady) begin
            sentD = 1'b1;
          end
        end else if (dnRspValid) begin
          ctl.install = 1'b1;
          sentD = 1'b0;
          stateD = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        ctl.useCap = 1'b1;
        ctl.access = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_INIT;
      clrQ   <= '0;
      sentQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      clrQ   <= clrD;
      sentQ  <= sentD;
    end
  end

  // R8
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && !dnReqReady) |=> (dnReqValid && $stable(dnReqWrite)));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && dnReqWrite && dnReqReady) |=> (dnReqValid && !dnReqWrite));

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !hit) |=> !reqReady);

  generate
    if (READ_ONLY) begin : g_roChk
      // R9
      ro_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(dnReqValid && dnReqWrite));
    end
  endgenerate

endmodule

// File: rtl/line_cache.sv
module line_cache
  import line_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES = 64,
  parameter bit READ_ONLY = 1'b0,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqMask,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              dnReqValid,
  input  logic              dnReqReady,
  output logic              dnReqWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [LINE_W-1:0] dnWdata,
  input  logic              dnRspValid,
  input  logic [LINE_W-1:0] dnRdata
);

  cacheCtl_t ctl;
  logic [IDX_W-1:0] clrIdx;
  logic hit;
  logic victimDirty;

  line_cache_control #(
    .NUM_LINES(NUM_LINES),
    .READ_ONLY(READ_ONLY)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .hit(hit),
    .victimDirty(victimDirty),
    .dnReqReady(dnReqReady),
    .dnRspValid(dnRspValid),
    .reqReady(reqReady),
    .dnReqValid(dnReqValid),
    .dnReqWrite(dnReqWrite),
    .ctl(ctl),
    .clrIdx(clrIdx)
  );

  line_cache_datapath #(
    .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES),
    .READ_ONLY(READ_ONLY)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .clrIdx(clrIdx),
    .reqWrite(reqWrite),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .reqMask(reqMask),
    .dnRdata(dnRdata),
    .hit(hit),
    .victimDirty(victimDirty),
    .dnAddr(dnAddr),
    .dnWdata(dnWdata),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

endmodule

// File: tb/line_cache_tb_top.sv
`timescale 1ns/1ps

module line_cache_mem #(
  parameter int MLINES = 64,
  parameter logic [31:0] BASE = 32'h8000_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         reqWrite,
  input  logic [31:0]  addr,
  input  logic [255:0] wdata,
  output logic         rspValid,
  output logic [255:0] rdata,
  output int           rdCount,
  output int           wrCount
);
  logic [255:0] lineMem [MLINES];
  logic readyQ;
  logic pend;
  int dly;
  int rLine;

  function automatic logic [255:0] initLine(int l);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = 32'hC0DE_0000 ^ (l << 8) ^ w;
    return r;
  endfunction

  function automatic int lineIdx(logic [31:0] a);
    return int'((a - BASE) >> 5) % MLINES;
  endfunction

  assign reqReady = readyQ;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      pend <= 1'b0;
      dly <= 0;
      rLine <= 0;
      rspValid <= 1'b0;
      rdata <= '0;
      rdCount <= 0;
      wrCount <= 0;
      for (int l = 0; l < MLINES; l++) lineMem[l] <= initLine(l);
    end else begin
      readyQ <= ($urandom % 4) != 0;
      rspValid <= 1'b0;
      if (reqValid && readyQ) begin
        if (reqWrite) begin
          lineMem[lineIdx(addr)] <= wdata;
          wrCount <= wrCount + 1;
        end else begin
          pend <= 1'b1;
          dly <= 2;
          rLine <= lineIdx(addr);
          rdCount <= rdCount + 1;
        end
      end
      if (pend) begin
        if (dly == 0) begin
          rspValid <= 1'b1;
          rdata <= lineMem[rLine];
          pend <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end
endmodule

module line_cache_tb_top;
  localparam int DL = 8;
  localparam int RL = 4;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0] reqMask = '0;
  logic reqValidD = 1'b0;
  logic reqValidR = 1'b0;
  logic selRo = 1'b0;

  logic dReady, dRspV, rReady, rRspV;
  logic [31:0] dRdata, rRdata;
  logic dDnV, dDnRdy, dDnW, dDnRspV, rDnV, rDnRdy, rDnW, rDnRspV;
  logic [31:0] dDnAddr, rDnAddr;
  logic [255:0] dDnWdata, dDnRdata, rDnWdata, rDnRdata;
  int dRd, dWr, rRd, rWr;

  line_cache #(.NUM_LINES(DL), .READ_ONLY(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValidD), .reqReady(dReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(dRspV), .rspRdata(dRdata), .dnReqValid(dDnV), .dnReqReady(dDnRdy),
    .dnReqWrite(dDnW), .dnAddr(dDnAddr), .dnWdata(dDnWdata),
    .dnRspValid(dDnRspV), .dnRdata(dDnRdata));

  line_cache_mem dMem_i (
    .clk(clk), .rstN(rstN), .reqValid(dDnV), .reqReady(dDnRdy), .reqWrite(dDnW),
    .addr(dDnAddr), .wdata(dDnWdata), .rspValid(dDnRspV), .rdata(dDnRdata),
    .rdCount(dRd), .wrCount(dWr));

  line_cache #(.NUM_LINES(RL), .READ_ONLY(1'b1)) roDut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValidR), .reqReady(rReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rRspV), .rspRdata(rRdata), .dnReqValid(rDnV), .dnReqReady(rDnRdy),
    .dnReqWrite(rDnW), .dnAddr(rDnAddr), .dnWdata(rDnWdata),
    .dnRspValid(rDnRspV), .dnRdata(rDnRdata));

  line_cache_mem roMem_i (
    .clk(clk), .rstN(rstN), .reqValid(rDnV), .reqReady(rDnRdy), .reqWrite(rDnW),
    .addr(rDnAddr), .wdata(rDnWdata), .rspValid(rDnRspV), .rdata(rDnRdata),
    .rdCount(rRd), .wrCount(rWr));

  logic curReady, curRspV;
  logic [31:0] curRdata;
  assign curReady = selRo ? rReady : dReady;
  assign curRspV  = selRo ? rRspV : dRspV;
  assign curRdata = selRo ? rRdata : dRdata;

  int checks = 0;
  int fails = 0;
  int readyDuringMiss = 0;
  int hsErr = 0;
  logic [31:0] refMem [64*8];

  function automatic logic [31:0] initWord(int l, int w);
    return 32'hC0DE_0000 ^ (l << 8) ^ w;
  endfunction

  function automatic logic [31:0] mergeW(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = m[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic int refIdx(logic [31:0] a);
    return (int'((a - BASE) >> 5) % 64) * 8 + int'(a[4:2]);
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // downstream handshake monitor (R8), sampled at negedge
  logic pV = 1'b0, pR = 1'b0, pW = 1'b0;
  logic [31:0] pA = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pV && !pR && !(dDnV && dDnW == pW && dDnAddr == pA)) hsErr++;
      pV = dDnV; pR = dDnRdy; pW = dDnW; pA = dDnAddr;
    end
  end

  task automatic doAcc(input bit ro, input bit wr, input logic [31:0] addr,
                       input logic [31:0] wd, input logic [3:0] mask,
                       output logic [31:0] rd, output int lat);
    selRo = ro;
    reqWrite = wr; reqAddr = addr; reqWdata = wd; reqMask = mask;
    if (ro) reqValidR = 1'b1; else reqValidD = 1'b1;
    while (!curReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValidD = 1'b0; reqValidR = 1'b0;
    lat = 1;
    while (!curRspV) begin
      if (curReady) readyDuringMiss++;
      @(negedge clk);
      lat++;
    end
    rd = curRdata;
  endtask

  // data-side access with reference update
  task automatic dAcc(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                      input logic [3:0] mask, output logic [31:0] rd,
                      output logic [31:0] exp, output int lat);
    int i;
    i = refIdx(addr);
    exp = refMem[i];
    if (wr) refMem[i] = mergeW(refMem[i], wd, mask);
    doAcc(1'b0, wr, addr, wd, mask, rd, lat);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [31:0] rd, exp, a;
    int lat, n, r0, w0, seed;
    seed = $urandom(32'd20240611);
    for (int l = 0; l < 64; l++)
      for (int w = 0; w < 8; w++) refMem[l*8 + w] = initWord(l, w);

    repeat (3) @(negedge clk);
    check(!dReady && !dRspV, "R1 reset outputs", {30'd0, dReady, dRspV}, 32'd0);
    rstN = 1'b1;
    n = 0;
    while (!dReady) begin @(negedge clk); n++; end
    check(n == DL, "R1 init sweep length", n, DL);

    // first access misses (R1, R4)
    r0 = dRd; w0 = dWr;
    dAcc(1'b0, BASE + 4, 0, 0, rd, exp, lat);
    check(rd == exp, "R4 miss read data", rd, exp);
    check(dRd == r0 + 1 && dWr == w0, "R1 first access fetches", dRd - r0, 1);

    // read hit (R2)
    r0 = dRd;
    dAcc(1'b0, BASE + 12, 0, 0, rd, exp, lat);
    check(lat == 1, "R2 hit latency", lat, 1);
    check(rd == exp && dRd == r0, "R2 hit data no traffic", rd, exp);

    // write hit merge (R3)
    r0 = dRd; w0 = dWr;
    dAcc(1'b1, BASE + 12, 32'h1122_3344, 4'b0101, rd, exp, lat);
    check(lat == 1 && dRd == r0 && dWr == w0, "R3 write hit no traffic", lat, 1);
    dAcc(1'b0, BASE + 12, 0, 0, rd, exp, lat);
    check(rd == mergeW(initWord(0, 3), 32'h1122_3344, 4'b0101) && rd == exp,
          "R3 merged bytes", rd, exp);

    // conflict with dirty victim (R6, R7)
    r0 = dRd; w0 = dWr;
    dAcc(1'b0, BASE + 8*32, 0, 0, rd, exp, lat);
    check(rd == exp, "R7 conflicting line data", rd, exp);
    check(dWr == w0 + 1 && dRd == r0 + 1, "R6 dirty victim written", dWr - w0, 1);
    check(dMem_i.lineMem[0][3*32 +: 32] == refMem[3], "R6 victim contents",
          dMem_i.lineMem[0][3*32 +: 32], refMem[3]);

    // clean victim (R6)
    w0 = dWr; r0 = dRd;
    dAcc(1'b0, BASE + 12, 0, 0, rd, exp, lat);
    check(dWr == w0 && dRd == r0 + 1, "R6 clean victim no write", dWr - w0, 0);
    check(rd == exp, "R6 data back from memory", rd, exp);

    // write miss allocate (R5)
    r0 = dRd;
    dAcc(1'b1, BASE + 3*32 + 20, 32'hDEAD_BEEF, 4'b1111, rd, exp, lat);
    check(dRd == r0 + 1, "R5 write miss fetches", dRd - r0, 1);
    dAcc(1'b0, BASE + 3*32 + 20, 0, 0, rd, exp, lat);
    check(rd == 32'hDEAD_BEEF && lat == 1, "R5 allocated word", rd, 32'hDEAD_BEEF);
    dAcc(1'b0, BASE + 3*32 + 16, 0, 0, rd, exp, lat);
    check(rd == initWord(3, 4), "R5 neighbour word fetched", rd, initWord(3, 4));
    w0 = dWr;
    dAcc(1'b0, BASE + 11*32, 0, 0, rd, exp, lat);
    check(dWr == w0 + 1 && dMem_i.lineMem[3][5*32 +: 32] == 32'hDEAD_BEEF,
          "R5 allocated line dirty", dMem_i.lineMem[3][5*32 +: 32], 32'hDEAD_BEEF);

    // different indices coexist (R7)
    dAcc(1'b0, BASE + 1*32, 0, 0, rd, exp, lat);
    dAcc(1'b0, BASE + 2*32, 0, 0, rd, exp, lat);
    r0 = dRd;
    dAcc(1'b0, BASE + 1*32 + 8, 0, 0, rd, exp, lat);
    check(lat == 1 && dRd == r0 && rd == exp, "R7 distinct index hit", lat, 1);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic wr;
      logic [3:0] m;
      a = BASE + (($urandom % 64) << 5) + (($urandom % 8) << 2);
      wr = ($urandom % 10) < 4;
      m = 4'($urandom);
      dAcc(wr, a, $urandom, m, rd, exp, lat);
      if (!wr) check(rd == exp, "R4 random read", rd, exp);
    end
    check(readyDuringMiss == 0, "R8 ready low during miss", readyDuringMiss, 0);
    check(hsErr == 0, "R8 downstream hold", hsErr, 0);

    // read-only instance (R9)
    doAcc(1'b1, 1'b0, BASE + 2*32 + 8, 0, 0, rd, lat);
    check(rd == initWord(2, 2), "R9 ro read", rd, initWord(2, 2));
    doAcc(1'b1, 1'b1, BASE + 2*32 + 8, 32'hFFFF_FFFF, 4'b1111, rd, lat);
    doAcc(1'b1, 1'b0, BASE + 2*32 + 8, 0, 0, rd, lat);
    check(rd == initWord(2, 2), "R9 ro write ignored", rd, initWord(2, 2));
    doAcc(1'b1, 1'b0, BASE + 6*32, 0, 0, rd, lat);
    doAcc(1'b1, 1'b0, BASE + 10*32, 0, 0, rd, lat);
    doAcc(1'b1, 1'b0, BASE + 2*32 + 8, 0, 0, rd, lat);
    check(rd == initWord(2, 2), "R9 ro refetch unchanged", rd, initWord(2, 2));
    check(rWr == 0, "R9 ro no downstream write", rWr, 0);

    finishRun();
  end
endmodule